// File: doc/BRIEF.md
# Per-Phase Resonant-Bank Voltage Regulator

This block regulates the output voltage of one inverter phase in discrete time using fixed-point arithmetic. A three-phase, four-wire supply uses three identical copies, one per phase. Each copy works only on its own phase error, so no rotating-frame or sequence-frame transform is needed. On every sample strobe the block reads the voltage command, the measured output voltage and the measured output-capacitor current. It then returns a phase voltage reference, measured against the fourth leg, which the modulator uses.

The result is the sum of four terms. The first is the command itself, fed forward. The second is a proportional term on the voltage error. The third is a bank of damped, phase-advanced resonant sections tuned to the fundamental and to the odd harmonics. The fourth is an active-damping term that is subtracted in proportion to the capacitor current. Each resonant section is a second-order difference equation. Its precomputed coefficients already contain that section's damping and its delay-compensating phase advance. All sections share one multiplier-accumulator and are evaluated one product per clock. The sequence therefore takes a fixed number of cycles after each strobe. Software loads the coefficients through a write port before operation.

Top module: `res_bank_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `vout` becomes 0, `done` becomes 0 and every coefficient becomes 0.
- R2: The error is e = vref − vmeas, held to 17 bits. The proportional term adds floor(Kp·e / 2^FRAC) to the output sum, with FRAC = 14 and Kp held at coefficient index 4·NSEC.
- R3: Section k (k = 0..NSEC−1) computes y = clampS(floor((b0·e + b1·e_prev + a1·y1 + a2·y2) / 2^FRAC)). Its coefficients are held at indices 4k, 4k+1, 4k+2 and 4k+3, in that order. Here e_prev is the error of the previous completed sample, and y1 and y2 are that section's last two outputs. clampS limits a value to the signed SW-bit range (SW = 24).
- R4: Every section keeps its own state. The outputs of all NSEC sections are added to the output sum.
- R5: Active damping subtracts floor(Kad·icap / 2^FRAC) from the sum, with Kad held at coefficient index 4·NSEC+1.
- R6: The command `vref` is added to the sum unscaled. With every coefficient zero, `vout` equals `vref`.
- R7: `vout` is the sum clamped to ±OUT_LIM (±32767 by default). It never wraps around.
- R8: `done` is a single-cycle pulse. It rises 4·NSEC+3 clock edges after the edge that accepts the strobe (31 by default), and `vout` changes only together with `done`.
- R9: A strobe that arrives while a computation is running is ignored. It produces no extra `done` pulse and does not change the running result or any state.
- R10: A high `clr` at a clock edge sets all section state and e_prev to zero. It also aborts a running computation, so no `done` follows and `vout` keeps its value. Coefficients are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the resonator state; aborts a running computation |
| strobe | input | 1 | Sample strobe; starts one evaluation |
| vref | input | DW (16) | Signed voltage command |
| vmeas | input | DW (16) | Signed measured output voltage |
| icap | input | DW (16) | Signed measured capacitor current |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | clog2(4·NSEC+2) (5) | Coefficient index |
| cfg_data | input | CW (18) | Signed coefficient, Q(CW−1−FRAC).FRAC |
| vout | output | DW (16) | Signed, saturated phase voltage reference |
| done | output | 1 | One-cycle pulse marking a new `vout` |

## Verification
A new result is due exactly 4·NSEC+3 edges after the edge that samples the strobe, which is 31 edges with the defaults. The driver records that cycle number next to the expected value when it queues an item. The monitor samples on the falling clock edge and checks both the value and the cycle of every `done` pulse. Any pulse that arrives with nothing queued counts as an error, and this covers ignored strobes and aborted runs. Cleared state is checked through later outputs, and the output held after an abort is checked directly at the port.

// File: rtl/rbc_pkg.sv
// Shared types for the resonant-bank regulator.
// Assumes: one product per clock on a single shared multiplier.
package rbc_pkg;

    // What the accumulator does with the product of the current step
    typedef enum logic [2:0] {
        K_IDLE,
        K_SEC_FIRST,
        K_SEC_MID,
        K_SEC_LAST,
        K_PROP,
        K_DAMP
    } op_kind_e;

    // Which operand feeds the shared multiplier
    typedef enum logic [2:0] {
        S_ERR,
        S_ERR_D,
        S_Y1,
        S_Y2,
        S_IC
    } opnd_sel_e;

endpackage

// File: rtl/rbc_coefs.sv
// Coefficient register file.
// Holds NCOEF signed coefficients. The index layout matches the step
// number of the sequencer: 4k..4k+3 are b0,b1,a1,a2 of section k, then
// Kp, then Kad. Writes to indices at or beyond NCOEF are dropped.
module rbc_coefs #(
    parameter int NCOEF = 30,
    parameter int CW    = 18,
    localparam int CAW  = $clog2(NCOEF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CAW-1:0]       addr,
    input  logic signed [CW-1:0] wdata,
    input  logic [CAW-1:0]       rd_idx,
    output logic signed [CW-1:0] rd_coef
);

    logic signed [CW-1:0] regs [NCOEF];

    // Store a coefficient; reset clears the whole file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCOEF; i++) regs[i] <= '0;
        end else if (we && int'(addr) < NCOEF) begin
            regs[addr] <= wdata;
        end
    end

    // Read port addressed by the current sequencer step
    always_comb begin
        rd_coef = '0;
        if (int'(rd_idx) < NCOEF) rd_coef = regs[rd_idx];
    end

    // R3: a write lands at the addressed index
    a_r3_coef_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(addr) < NCOEF) |=> (regs[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/rbc_seq.sv
// Step sequencer for the shared multiply-accumulate unit.
// A strobe accepted while idle starts NOPS = 4*NSEC+2 steps, one per
// clock. Strobes during a run are ignored. clr aborts the run. fin
// pulses on the clock after the last step.
module rbc_seq
    import rbc_pkg::*;
#(
    parameter int NSEC  = 7,
    localparam int NOPS = 4 * NSEC + 2,
    localparam int OPW  = $clog2(NOPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           strobe,
    output logic           start,
    output logic           busy,
    output logic           fin,
    output logic [OPW-1:0] op,
    output op_kind_e       kind,
    output opnd_sel_e      sel
);

    localparam logic [OPW-1:0] LAST_OP = OPW'(NOPS - 1);
    localparam logic [OPW-1:0] PROP_OP = OPW'(4 * NSEC);

    assign start = strobe && !busy && !clr;

    // Step counter and run flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            op   <= '0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                op   <= '0;
            end else if (busy) begin
                if (op == LAST_OP) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end else begin
                    op <= op + 1'b1;
                end
            end
        end
    end

    // Decode the step into accumulator action and operand choice
    always_comb begin
        kind = K_IDLE;
        sel  = S_ERR;
        if (busy) begin
            if (op < PROP_OP) begin
                unique case (op[1:0])
                    2'd0: begin kind = K_SEC_FIRST; sel = S_ERR;   end
                    2'd1: begin kind = K_SEC_MID;   sel = S_ERR_D; end
                    2'd2: begin kind = K_SEC_MID;   sel = S_Y1;    end
                    default: begin kind = K_SEC_LAST; sel = S_Y2;  end
                endcase
            end else if (op == PROP_OP) begin
                kind = K_PROP;
                sel  = S_ERR;
            end else begin
                kind = K_DAMP;
                sel  = S_IC;
            end
        end
    end

    // R8: an accepted strobe starts a run
    a_r8_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: a running sequence only advances; a strobe never restarts it
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr) |=> (!busy || op == $past(op) + 1'b1));

    // R8: fin is issued only once the run is over
    a_r8_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> !busy);

endmodule

// File: rtl/rbc_state.sv
// Resonator state file: the last two outputs of each section.
// A write shifts y1 into y2 and stores the new output in y1.
// clr zeroes every section in one clock.
module rbc_state #(
    parameter int NSEC = 7,
    parameter int SW   = 24,
    localparam int SIW = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [SIW-1:0]       wr_idx,
    input  logic signed [SW-1:0] wr_val,
    input  logic [SIW-1:0]       rd_idx,
    output logic signed [SW-1:0] rd_y1,
    output logic signed [SW-1:0] rd_y2
);

    logic signed [SW-1:0] y1 [NSEC];
    logic signed [SW-1:0] y2 [NSEC];
    logic [NSEC-1:0]      nz;

    // Section history update, cleared by reset or clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < NSEC; i++) begin
                y1[i] <= '0;
                y2[i] <= '0;
            end
        end else if (wr_en && int'(wr_idx) < NSEC) begin
            y2[wr_idx] <= y1[wr_idx];
            y1[wr_idx] <= wr_val;
        end
    end

    // Read the history of the section being evaluated
    always_comb begin
        rd_y1 = '0;
        rd_y2 = '0;
        if (int'(rd_idx) < NSEC) begin
            rd_y1 = y1[rd_idx];
            rd_y2 = y2[rd_idx];
        end
    end

    // Per-section nonzero flags, used to check the clear
    for (genvar g = 0; g < NSEC; g++) begin : g_nz
        assign nz[g] = (|y1[g]) || (|y2[g]);
    end

    // R10: clr leaves no section history behind
    a_r10_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (nz == '0));

endmodule

// File: rtl/res_bank_ctrl.sv
// Per-phase resonant-bank voltage regulator (top).
// Assumes: coefficients are loaded while idle; strobes come at least
// 4*NSEC+3 clocks apart (faster ones are dropped). The output is
// vref + Kp*e + sum of sections - Kad*icap, clamped to +/-OUT_LIM.
module res_bank_ctrl
    import rbc_pkg::*;
#(
    parameter int DW      = 16,
    parameter int CW      = 18,
    parameter int FRAC    = 14,
    parameter int NSEC    = 7,
    parameter int SW      = 24,
    parameter int OUT_LIM = 32767
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic                            strobe,
    input  logic signed [DW-1:0]            vref,
    input  logic signed [DW-1:0]            vmeas,
    input  logic signed [DW-1:0]            icap,
    input  logic                            cfg_we,
    input  logic [$clog2(4*NSEC+2)-1:0]     cfg_addr,
    input  logic signed [CW-1:0]            cfg_data,
    output logic signed [DW-1:0]            vout,
    output logic                            done
);

    localparam int NCOEF = 4 * NSEC + 2;
    localparam int OPW   = $clog2(NCOEF);
    localparam int SIW   = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int PW    = SW + CW;
    localparam int AW    = PW + 4;
    localparam logic signed [AW-1:0] S_MAX = AW'((64'sd1 <<< (SW - 1)) - 1);
    localparam logic signed [AW-1:0] S_MIN = ~S_MAX;
    localparam logic signed [AW-1:0] O_MAX = AW'(OUT_LIM);
    localparam logic signed [AW-1:0] O_MIN = -O_MAX;

    // Clamp a wide sum into the section state range
    function automatic logic signed [SW-1:0] clamp_state(input logic signed [AW-1:0] v);
        if (v > S_MAX)      return S_MAX[SW-1:0];
        else if (v < S_MIN) return S_MIN[SW-1:0];
        else                return v[SW-1:0];
    endfunction

    // Clamp a wide sum into the output range
    function automatic logic signed [DW-1:0] clamp_out(input logic signed [AW-1:0] v);
        if (v > O_MAX)      return O_MAX[DW-1:0];
        else if (v < O_MIN) return O_MIN[DW-1:0];
        else                return v[DW-1:0];
    endfunction

    logic                 start, busy, fin;
    logic [OPW-1:0]       op;
    op_kind_e             kind;
    opnd_sel_e            sel;
    logic signed [CW-1:0] coef;
    logic signed [SW-1:0] y1, y2, y_new;
    logic [SIW-1:0]       sec_idx;

    logic signed [DW:0]   err_in, e_q, e1_q;
    logic signed [DW-1:0] ic_q, ff_q;
    logic signed [SW-1:0] opnd;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_x, prod_sh, sec_acc, sec_sum, tot, out_sum, y_x, vout_x;

    rbc_seq #(.NSEC(NSEC)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
        .start(start), .busy(busy), .fin(fin),
        .op(op), .kind(kind), .sel(sel)
    );

    rbc_coefs #(.NCOEF(NCOEF), .CW(CW)) u_coefs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_data), .rd_idx(op), .rd_coef(coef)
    );

    assign sec_idx = SIW'(op >> 2);

    rbc_state #(.NSEC(NSEC), .SW(SW)) u_state (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr_en(kind == K_SEC_LAST), .wr_idx(sec_idx), .wr_val(y_new),
        .rd_idx(sec_idx), .rd_y1(y1), .rd_y2(y2)
    );

    // Error with one guard bit so the difference never wraps
    assign err_in = {vref[DW-1], vref} - {vmeas[DW-1], vmeas};

    // Operand for the shared multiplier
    always_comb begin
        unique case (sel)
            S_ERR:   opnd = {{(SW-DW-1){e_q[DW]}}, e_q};
            S_ERR_D: opnd = {{(SW-DW-1){e1_q[DW]}}, e1_q};
            S_Y1:    opnd = y1;
            S_Y2:    opnd = y2;
            default: opnd = {{(SW-DW){ic_q[DW-1]}}, ic_q};
        endcase
    end

    // Product, section result and clamped output sum
    always_comb begin
        prod    = opnd * coef;
        prod_x  = {{(AW-PW){prod[PW-1]}}, prod};
        prod_sh = prod_x >>> FRAC;
        sec_sum = (sec_acc + prod_x) >>> FRAC;
        y_new   = clamp_state(sec_sum);
        y_x     = {{(AW-SW){y_new[SW-1]}}, y_new};
        out_sum = tot + {{(AW-DW){ff_q[DW-1]}}, ff_q};
        vout_x  = {{(AW-DW){vout[DW-1]}}, vout};
    end

    // Input capture, accumulation and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q     <= '0;
            e1_q    <= '0;
            ic_q    <= '0;
            ff_q    <= '0;
            sec_acc <= '0;
            tot     <= '0;
            vout    <= '0;
            done    <= 1'b0;
        end else if (clr) begin
            e1_q <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                e_q  <= err_in;
                ic_q <= icap;
                ff_q <= vref;
                tot  <= '0;
            end
            unique case (kind)
                K_SEC_FIRST: sec_acc <= prod_x;
                K_SEC_MID:   sec_acc <= sec_acc + prod_x;
                K_SEC_LAST:  tot     <= tot + y_x;
                K_PROP:      tot     <= tot + prod_sh;
                K_DAMP:      tot     <= tot - prod_sh;
                default: ;
            endcase
            if (fin) begin
                vout <= clamp_out(out_sum);
                done <= 1'b1;
                e1_q <= e_q;
            end
        end
    end

    // R8: done follows the end of the step sequence by one clock
    a_r8_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fin));

    // R8: done lasts exactly one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the output moves only when done is raised
    a_r8_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(vout));

    // R7: a published output stays inside the clamp range
    a_r7_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vout_x <= O_MAX && vout_x >= O_MIN));

    // R10: clear suppresses the pending result
    a_r10_clear_abort: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !done);

endmodule

// File: tb/res_bank_ctrl_bench.sv
// Scoreboard bench: the driver queues expected value and due cycle,
// the monitor pops and compares on every done pulse.
module res_bank_ctrl_bench;

    localparam int  DW    = 16;
    localparam int  CW    = 18;
    localparam int  FRAC  = 14;
    localparam int  NSEC  = 7;
    localparam int  SW    = 24;
    localparam int  NCOEF = 4 * NSEC + 2;
    localparam int  LAT   = 4 * NSEC + 3;
    localparam int  IKP   = 4 * NSEC;
    localparam int  IKAD  = 4 * NSEC + 1;
    localparam longint SMAX = (64'sd1 <<< (SW - 1)) - 1;
    localparam longint OLIM = 32767;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic strobe = 1'b0;
    logic signed [DW-1:0] vref = '0, vmeas = '0, icap = '0;
    logic cfg_we = 1'b0;
    logic [$clog2(NCOEF)-1:0] cfg_addr = '0;
    logic signed [CW-1:0] cfg_data = '0;
    logic signed [DW-1:0] vout;
    logic done;

    always #5 clk = ~clk;

    res_bank_ctrl u_res_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .strobe(strobe),
        .vref(vref), .vmeas(vmeas), .icap(icap),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .vout(vout), .done(done)
    );

    typedef struct {
        longint val;
        int     cyc;
        string  tag;
    } exp_t;

    exp_t   q[$];
    int     cyc = 0;
    int     nchk = 0;
    int     nfail = 0;
    longint mc [NCOEF];
    longint my1 [NSEC];
    longint my2 [NSEC];
    longint me1 = 0;
    longint last_out = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint clampl(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Reference model of one sample, built from R2..R7
    task automatic model_step(input longint vr, input longint vm, input longint ic, output longint res);
        longint e, acc, y, tot;
        e = vr - vm;
        tot = 0;
        for (int k = 0; k < NSEC; k++) begin
            acc = mc[4*k]*e + mc[4*k+1]*me1 + mc[4*k+2]*my1[k] + mc[4*k+3]*my2[k];
            y = clampl(acc >>> FRAC, -SMAX - 1, SMAX);
            my2[k] = my1[k];
            my1[k] = y;
            tot += y;
        end
        tot += (mc[IKP] * e) >>> FRAC;
        tot -= (mc[IKAD] * ic) >>> FRAC;
        me1 = e;
        res = clampl(tot + vr, -OLIM, OLIM);
    endtask

    task automatic model_clear();
        for (int k = 0; k < NSEC; k++) begin
            my1[k] = 0;
            my2[k] = 0;
        end
        me1 = 0;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_coef(input int idx, input longint val);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = idx[$clog2(NCOEF)-1:0];
        cfg_data = val[CW-1:0];
        mc[idx]  = val;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    // Driver: queue expectation, pulse strobe, wait past the result
    task automatic run_sample(input longint vr, input longint vm, input longint ic, input string tag);
        exp_t e;
        longint r;
        @(negedge clk);
        model_step(vr, vm, ic, r);
        e.val = r;
        e.cyc = cyc + LAT + 1;
        e.tag = tag;
        q.push_back(e);
        last_out = r;
        vref   = vr[DW-1:0];
        vmeas  = vm[DW-1:0];
        icap   = ic[DW-1:0];
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (LAT + 1) @(negedge clk);
    endtask

    // Monitor: compare value and arrival cycle of every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R9/R10 unexpected done", longint'(vout), 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(longint'(vout) == e.val, e.tag, longint'(vout), e.val);
                check(cyc == e.cyc, "R8 latency", cyc, e.cyc);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R8 watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCOEF; i++) mc[i] = 0;
        model_clear();
        repeat (4) @(negedge clk);
        check(vout == 0, "R1 reset vout", longint'(vout), 0);
        check(done == 1'b0, "R1 reset done", longint'(done), 0);
        rst_n = 1'b1;

        // R6: all coefficients zero after reset, output is the command
        run_sample(1234, 999, 500, "R6 feedforward");
        run_sample(-20000, 5, -7, "R6 feedforward negative");

        // R2: proportional path, including floor on a negative half
        write_coef(IKP, 8192);
        run_sample(1000, 400, 0, "R2 proportional");
        run_sample(0, 3, 0, "R2 proportional floor");
        run_sample(-500, 2500, 0, "R2 proportional negative");

        // R5: active damping subtracts the scaled capacitor current
        write_coef(IKP, 0);
        write_coef(IKAD, 16384);
        run_sample(100, 100, 1234, "R5 damping");
        run_sample(100, 100, -777, "R5 damping negative");

        // R7: clamp at both ends, symmetric limit
        write_coef(IKAD, 0);
        write_coef(IKP, 131071);
        run_sample(30000, -30000, 0, "R7 clamp high");
        run_sample(-30000, 30000, 0, "R7 clamp low");

        // R3/R4: two distinct sections with their own history
        write_coef(IKP, 8192);
        write_coef(IKAD, 4096);
        write_coef(0, 200);   write_coef(1, -190);
        write_coef(2, 32000); write_coef(3, -16300);
        write_coef(8, 150);   write_coef(9, -140);
        write_coef(10, 30000); write_coef(11, -16300);
        for (int k = 0; k < 12; k++) begin
            run_sample((k * 3000) % 20000 - 10000, (k * 3000) % 20000 - 10500 + k * 37,
                       k * 1000 - 5000, "R3/R4 resonator bank");
        end

        // R9: second strobe during the run is ignored
        begin
            exp_t e;
            longint r;
            @(negedge clk);
            model_step(4000, 3000, 200, r);
            e.val = r; e.cyc = cyc + LAT + 1; e.tag = "R9 busy strobe";
            q.push_back(e);
            last_out = r;
            vref = 16'sd4000; vmeas = 16'sd3000; icap = 16'sd200;
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            repeat (5) @(negedge clk);
            vref = -16'sd9000; vmeas = 16'sd9000; icap = 16'sd3000;
            strobe = 1'b1;
            @(negedge clk);
            strobe = 1'b0;
            repeat (LAT + 4) @(negedge clk);
            check(q.size() == 0, "R9 single result", q.size(), 0);
        end
        run_sample(2000, 1900, 50, "R9 state untouched");

        // R10: clear while busy aborts and keeps vout
        @(negedge clk);
        vref = 16'sd5000; vmeas = 16'sd0; icap = 16'sd0;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        repeat (6) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        repeat (LAT + 4) @(negedge clk);
        check(longint'(vout) == last_out, "R10 vout held after abort", longint'(vout), last_out);
        run_sample(3000, 2000, 100, "R10 state cleared, coefs kept");
        run_sample(-3000, -2500, -100, "R10 after clear");

        // R10: clear while idle
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        model_clear();
        run_sample(1500, 1000, 0, "R10 idle clear");

        repeat (5) @(negedge clk);
        check(q.size() == 0, "R8 all results arrived", q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule